// File: doc/BRIEF.md
# SPI Command-Decoding Control Slave

This block is the host-facing control port of a measurement datapath. A microcontroller talks to it over a four-wire SPI link in mode 0. Inside each chip-select frame the top three bits of the first 16-bit word choose one of eight operations. The operations are: loading a sweep point's configuration, writing a control register, reading status and an identification constant, streaming out the latest sample result, streaming out the latest DFT result, reading the ADC minimum/maximum trackers, and firing single-cycle action strobes that resume a halted sweep or clear the limit trackers.

The SPI pins are oversampled in the system clock domain through synchronizers. When chip select falls, all result and limit inputs are copied into a shadow buffer. MISO then streams from that copy, so upstream logic may update its results at any time without tearing a frame. A status word carries a sample-available flag and a sweep-halted flag. An interrupt line raises when any status bit enabled by a mask register is set.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, miso_o, irq_o, resume_o, lim_reset_o and pcfg_we_o are 0 and every register in regs_o is 0x0000.
- R2: A frame whose first word has top bits 100 writes its second word into register regs_o[first_word[7:0]]. An address of NREGS (16) or above changes no register.
- R3: On MISO, the first word of every frame is the status word, where bit 2 = sample available, bit 4 = sweep halted, and all other bits are 0. In a status frame (top bits 010), the second word is 0xF0A5 and later words are 0x0000.
- R4: A sample read (top bits 110) is 20 words long. Word 0 is status. Words 1..18 carry smp_val_i[0] through smp_val_i[5] in index order. Index 0..5 means RefQ, RefI, Port2 Q, Port2 I, Port1 Q, Port1 I. Word 19 is {stage[2:0], point[12:0]}.
- R5: Each 48-bit value goes out as three words, bits 15:0 first, then 31:16, then 47:32. Each word is sent MSB first.
- R6: A DFT read (top bits 101) returns dft_val_i[0..3] as words 1..12, in index order and word order as in R5. Index 0..3 means Port2 imag, Port2 real, Port1 imag, Port1 real.
- R7: A limit read (top bits 111) returns lim_val_i[0..5] as words 1..6. Index 0..5 means Port1 max, Port1 min, Port2 max, Port2 min, Ref max, Ref min.
- R8: Streamed result and limit words equal the input values present when chip select fell. Input changes during the frame have no effect on them.
- R9: smp_valid_i sets the sample-available bit. The command word of a sample read clears it. A status read leaves it set.
- R10: In a point-config frame (top bits 000), words 1..6 each produce one pcfg_we_o pulse. The pulse carries pcfg_point_o = word0[12:0], pcfg_sel_o = word number − 1, and pcfg_data_o = the word. Words after the sixth produce no pulse.
- R11: Command 001 gives exactly one one-cycle resume_o pulse, and command 011 gives exactly one one-cycle lim_reset_o pulse. Each pulse comes after its command word. No other command pulses either line.
- R12: irq_o is the OR of (status & register 3). With register 3 at zero, irq_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | SPI clock, mode 0 |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from host |
| miso_o | output | 1 | SPI data to host, 0 when deselected |
| regs_o | output | 16x16 | Register file contents |
| smp_val_i | input | 6x48 | Sample result values (R4 index order) |
| smp_point_i | input | 13 | Point number of the sample result |
| smp_stage_i | input | 3 | Stage number of the sample result |
| smp_valid_i | input | 1 | New sample result strobe |
| dft_val_i | input | 4x48 | DFT result values (R6 index order) |
| lim_val_i | input | 6x16 | ADC limit values (R7 index order) |
| sweep_halted_i | input | 1 | Sweep engine is halted |
| pcfg_we_o | output | 1 | Point configuration word write strobe |
| pcfg_point_o | output | 13 | Point index of the write |
| pcfg_sel_o | output | 3 | Word slot 0..5 within the point entry |
| pcfg_data_o | output | 16 | Configuration word |
| resume_o | output | 1 | Resume-sweep strobe |
| lim_reset_o | output | 1 | Limit-tracker clear strobe |
| irq_o | output | 1 | Masked interrupt |

## Verification
The hardest situation to create from the ports is a result input that changes in the middle of a streaming frame. This has to happen after the shadow copy is taken but before the affected words are shifted out. The bench builds each frame word by word. It overwrites the sample and DFT inputs right after the command word, then checks that every later word still matches the values held before chip select fell. Clearing the sample-available flag is observed through the status word of the next frame and through the interrupt line with the mask set.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  typedef enum logic [2:0] {
    OP_PCFG   = 3'd0,
    OP_RESUME = 3'd1,
    OP_STAT   = 3'd2,
    OP_LIMRST = 3'd3,
    OP_WRREG  = 3'd4,
    OP_DFT    = 3'd5,
    OP_SMP    = 3'd6,
    OP_LIM    = 3'd7
  } op_e;

  localparam int unsigned WORD_W        = 16;
  localparam logic [15:0] ID_WORD       = 16'hF0A5;
  localparam int unsigned STAT_SMP_BIT  = 2;
  localparam int unsigned STAT_HALT_BIT = 4;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W            = 3,
  parameter int unsigned STAGES       = 2,
  parameter logic [W-1:0] RST_VAL     = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_shift_word.sv
module spi_shift_word #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,   // chip select fell
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mosi_i,
  input  logic [WORD_W-1:0] first_i,   // word shown before the first edge
  input  logic [WORD_W-1:0] next_i,    // word loaded after each completed word
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              tx_msb_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic [CNT_W-1:0]  bit_cnt_q;
  logic [WORD_W-1:0] rx_q, tx_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      pend_q     <= 1'b0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      if (start_i) begin
        bit_cnt_q <= '0;
        tx_q      <= first_i;
        pend_q    <= 1'b0;
      end else if (rise_i) begin
        rx_q      <= {rx_q[WORD_W-2:0], mosi_i};
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q == CNT_W'(WORD_W-1)) begin
          word_o     <= {rx_q[WORD_W-2:0], mosi_i};
          word_vld_o <= 1'b1;
          pend_q     <= 1'b1;
        end
      end else if (fall_i) begin
        if (pend_q) begin
          tx_q   <= next_i;
          pend_q <= 1'b0;
        end else begin
          tx_q <= {tx_q[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  assign tx_msb_o = tx_q[WORD_W-1];
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile #(
  parameter int unsigned NREGS = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [NREGS-1:0][DW-1:0]  regs_o
);
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_o[g] <= '0;
      else if (we_i && addr_i == AW'(g))           regs_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_ctl_pkg::*;
#(
  parameter int unsigned NREGS       = 16,
  parameter int unsigned MASK_ADDR   = 3,
  parameter int unsigned VAL_W       = 48,
  parameter int unsigned SMP_VALS    = 6,
  parameter int unsigned DFT_VALS    = 4,
  parameter int unsigned LIM_VALS    = 6,
  parameter int unsigned PT_W        = 13,
  parameter int unsigned PCFG_WORDS  = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             sck_i,
  input  logic                             cs_ni,
  input  logic                             mosi_i,
  output logic                             miso_o,
  output logic [NREGS-1:0][WORD_W-1:0]     regs_o,
  input  logic [SMP_VALS-1:0][VAL_W-1:0]   smp_val_i,
  input  logic [PT_W-1:0]                  smp_point_i,
  input  logic [WORD_W-PT_W-1:0]           smp_stage_i,
  input  logic                             smp_valid_i,
  input  logic [DFT_VALS-1:0][VAL_W-1:0]   dft_val_i,
  input  logic [LIM_VALS-1:0][WORD_W-1:0]  lim_val_i,
  input  logic                             sweep_halted_i,
  output logic                             pcfg_we_o,
  output logic [PT_W-1:0]                  pcfg_point_o,
  output logic [$clog2(PCFG_WORDS)-1:0]    pcfg_sel_o,
  output logic [WORD_W-1:0]                pcfg_data_o,
  output logic                             resume_o,
  output logic                             lim_reset_o,
  output logic                             irq_o
);
  localparam int unsigned PARTS  = VAL_W / WORD_W;
  localparam int unsigned STG_W  = WORD_W - PT_W;
  localparam int unsigned SMP_WORDS = 1 + PARTS * SMP_VALS + 1;
  localparam int unsigned IDX_W  = $clog2(SMP_WORDS + 1);
  localparam int unsigned SEL_W  = $clog2(PCFG_WORDS);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  // pin synchronizers and edge detect
  logic sck_s, cs_s, mosi_s, sck_q, cs_q;
  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i, .rst_ni, .d_i({mosi_i, cs_ni, sck_i}), .q_o({mosi_s, cs_s, sck_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
    end
  end

  logic active, rise, fall, cs_fall;
  assign active  = ~cs_s;
  assign rise    = active & sck_s & ~sck_q;
  assign fall    = active & ~sck_s & sck_q;
  assign cs_fall = cs_q & ~cs_s;

  // status
  logic smp_avail_q, halt_q;
  logic [WORD_W-1:0] status_w, next_w, word_w;
  logic word_vld, tx_msb;
  logic [IDX_W-1:0] word_idx_q;
  op_e  op_q;
  logic [PT_W-1:0] arg_q;
  logic first_vld, clr_smp;

  always_comb begin
    status_w = '0;
    status_w[STAT_SMP_BIT]  = smp_avail_q;
    status_w[STAT_HALT_BIT] = halt_q;
  end

  spi_shift_word #(.WORD_W(WORD_W)) u_shift (
    .clk_i, .rst_ni, .start_i(cs_fall), .rise_i(rise), .fall_i(fall),
    .mosi_i(mosi_s), .first_i(status_w), .next_i(next_w),
    .word_o(word_w), .word_vld_o(word_vld), .tx_msb_o(tx_msb)
  );

  assign miso_o    = tx_msb & active;
  assign first_vld = word_vld && (word_idx_q == '0);
  assign clr_smp   = first_vld && (word_w[WORD_W-1 -: 3] == OP_SMP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_idx_q  <= '0;
      op_q        <= OP_PCFG;
      arg_q       <= '0;
      smp_avail_q <= 1'b0;
      halt_q      <= 1'b0;
    end else begin
      halt_q <= sweep_halted_i;
      if (smp_valid_i)  smp_avail_q <= 1'b1;
      else if (clr_smp) smp_avail_q <= 1'b0;
      if (cs_fall) word_idx_q <= '0;
      else if (word_vld && word_idx_q != IDX_MAX) word_idx_q <= word_idx_q + 1'b1;
      if (first_vld) begin
        op_q  <= op_e'(word_w[WORD_W-1 -: 3]);
        arg_q <= word_w[PT_W-1:0];
      end
    end
  end

  // result shadow, taken as the frame opens
  logic [SMP_VALS-1:0][VAL_W-1:0]  smp_snap;
  logic [DFT_VALS-1:0][VAL_W-1:0]  dft_snap;
  logic [LIM_VALS-1:0][WORD_W-1:0] lim_snap;
  logic [WORD_W-1:0]               tag_snap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_snap <= '0;
      dft_snap <= '0;
      lim_snap <= '0;
      tag_snap <= '0;
    end else if (cs_fall) begin
      smp_snap <= smp_val_i;
      dft_snap <= dft_val_i;
      lim_snap <= lim_val_i;
      tag_snap <= {smp_stage_i, smp_point_i};
    end
  end

  always_comb begin
    next_w = '0;
    case (op_q)
      OP_STAT: if (word_idx_q == IDX_W'(1)) next_w = ID_WORD;
      OP_SMP: begin
        for (int v = 0; v < SMP_VALS; v++)
          for (int p = 0; p < PARTS; p++)
            if (int'(word_idx_q) == 1 + PARTS*v + p) next_w = smp_snap[v][p*WORD_W +: WORD_W];
        if (int'(word_idx_q) == 1 + PARTS*SMP_VALS) next_w = tag_snap;
      end
      OP_DFT: begin
        for (int v = 0; v < DFT_VALS; v++)
          for (int p = 0; p < PARTS; p++)
            if (int'(word_idx_q) == 1 + PARTS*v + p) next_w = dft_snap[v][p*WORD_W +: WORD_W];
      end
      OP_LIM: begin
        for (int k = 0; k < LIM_VALS; k++)
          if (int'(word_idx_q) == 1 + k) next_w = lim_snap[k];
      end
      default: ;
    endcase
  end

  // register file
  logic rf_we;
  assign rf_we = word_vld && (op_q == OP_WRREG) && (word_idx_q == IDX_W'(1));

  spi_regfile #(.NREGS(NREGS), .DW(WORD_W), .AW(8)) u_rf (
    .clk_i, .rst_ni, .we_i(rf_we), .addr_i(arg_q[7:0]), .wdata_i(word_w), .regs_o
  );

  logic [WORD_W-1:0] mask_w;
  assign mask_w = regs_o[MASK_ADDR];
  assign irq_o  = |(status_w & mask_w);

  // point config and strobes
  assign pcfg_we_o    = word_vld && (op_q == OP_PCFG) && (word_idx_q != '0)
                        && (word_idx_q <= IDX_W'(PCFG_WORDS));
  assign pcfg_point_o = arg_q;
  assign pcfg_sel_o   = SEL_W'(word_idx_q - IDX_W'(1));
  assign pcfg_data_o  = word_w;
  assign resume_o     = first_vld && (word_w[WORD_W-1 -: 3] == OP_RESUME);
  assign lim_reset_o  = first_vld && (word_w[WORD_W-1 -: 3] == OP_LIMRST);
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned PCFG_WORDS = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              miso_o,
  input logic              resume_o,
  input logic              lim_reset_o,
  input logic              pcfg_we_o,
  input logic [SEL_W-1:0]  pcfg_sel_o,
  input logic [15:0]       mask_i,
  input logic              irq_o
);
  // R11
  resume_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o);
  // R11
  limrst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_reset_o |=> !lim_reset_o);
  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(resume_o && lim_reset_o));
  // R10
  pcfg_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcfg_we_o |-> (int'(pcfg_sel_o) < PCFG_WORDS));
  // R10
  pcfg_no_strobe_mix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcfg_we_o |-> !(resume_o || lim_reset_o));
  // R3
  miso_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2)) |-> !miso_o);
  // R12
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == 16'h0) |-> !irq_o);
endmodule

bind spi_cmd_slave spi_cmd_slave_chk #(.SEL_W(SEL_W), .PCFG_WORDS(PCFG_WORDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .miso_o(miso_o),
  .resume_o(resume_o), .lim_reset_o(lim_reset_o), .pcfg_we_o(pcfg_we_o),
  .pcfg_sel_o(pcfg_sel_o), .mask_i(mask_w), .irq_o(irq_o)
);

// File: tb/sim_spi_cmd_slave.sv
module sim_spi_cmd_slave;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [15:0][15:0] regs;
  logic [5:0][47:0] smp_val = '0, smp_ref;
  logic [12:0] smp_point = '0;
  logic [2:0]  smp_stage = '0;
  logic        smp_valid = 1'b0;
  logic [3:0][47:0] dft_val = '0, dft_ref;
  logic [5:0][15:0] lim_val = '0;
  logic        halted = 1'b0;
  logic        pcfg_we, resume, lim_reset, irq;
  logic [12:0] pcfg_point;
  logic [2:0]  pcfg_sel;
  logic [15:0] pcfg_data;

  always #2.5 clk = ~clk;

  spi_cmd_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi), .miso_o(miso),
    .regs_o(regs), .smp_val_i(smp_val), .smp_point_i(smp_point), .smp_stage_i(smp_stage),
    .smp_valid_i(smp_valid), .dft_val_i(dft_val), .lim_val_i(lim_val),
    .sweep_halted_i(halted), .pcfg_we_o(pcfg_we), .pcfg_point_o(pcfg_point),
    .pcfg_sel_o(pcfg_sel), .pcfg_data_o(pcfg_data), .resume_o(resume),
    .lim_reset_o(lim_reset), .irq_o(irq)
  );

  int tests = 0, fails = 0;
  logic [15:0] exp_v[$];
  string       exp_t[$];
  logic [15:0] mon_word;
  event        word_ev;
  logic [15:0] rmodel [16];

  int res_cnt = 0, lrs_cnt = 0, pc_n = 0;
  logic [15:0] pc_data [16];
  logic [2:0]  pc_sel  [16];
  logic [12:0] pc_pt   [16];

  always @(posedge clk) begin
    if (resume)    res_cnt <= res_cnt + 1;
    if (lim_reset) lrs_cnt <= lrs_cnt + 1;
    if (pcfg_we && pc_n < 16) begin
      pc_data[pc_n] <= pcfg_data;
      pc_sel[pc_n]  <= pcfg_sel;
      pc_pt[pc_n]   <= pcfg_point;
      pc_n          <= pc_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(word_ev);
    if (exp_v.size() == 0) chk("R3 unexpected word", 32'(mon_word), 32'hDEAD);
    else chk(exp_t.pop_front(), 32'(mon_word), 32'(exp_v.pop_front()));
  end

  task automatic cs_lo();
    @(negedge clk); cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] tx, input logic [15:0] exp, input string tag);
    logic [15:0] rx;
    exp_v.push_back(exp);
    exp_t.push_back(tag);
    for (int b = 15; b >= 0; b--) begin
      mosi = tx[b];
      repeat (H) @(negedge clk);
      rx[b] = miso;
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
    mon_word = rx;
    -> word_ev;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [15:0] v, input logic [15:0] st);
    cs_lo();
    xfer({8'h80, a}, st, "R3 status on write");
    xfer(v, 16'h0000, "R2 write data word miso");
    cs_hi();
    if (a < 16) rmodel[a] = v;
  endtask

  task automatic chk_regs(input string tag);
    for (int i = 0; i < 16; i++) chk(tag, 32'(regs[i]), 32'(rmodel[i]));
  endtask

  task automatic stat_rd(input logic [15:0] st, input string tag);
    cs_lo();
    xfer(16'h4000, st, tag);
    xfer(16'h0000, 16'hF0A5, "R3 id word");
    xfer(16'h0000, 16'h0000, "R3 trailing word");
    cs_hi();
  endtask

  initial begin
    int r0, l0, p0;
    for (int i = 0; i < 16; i++) rmodel[i] = 16'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 miso", 32'(miso), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 strobes", 32'({resume, lim_reset, pcfg_we}), 0);
    chk_regs("R1 regs");

    stat_rd(16'h0000, "R3 idle status");

    // R2 writes
    wr_reg(8'd5, 16'hBEEF, 16'h0000);
    chk("R2 reg5", 32'(regs[5]), 32'hBEEF);
    wr_reg(8'd15, 16'h0F0F, 16'h0000);
    wr_reg(8'h20, 16'h1234, 16'h0000);
    chk_regs("R2 out-of-range write ignored");

    // R12 mask sample bit
    wr_reg(8'd3, 16'h0004, 16'h0000);
    chk("R12 irq masked idle", 32'(irq), 0);

    // sample result arrives
    for (int v = 0; v < 6; v++)
      smp_val[v] = {8'hA0 + 8'(v), 8'h01, 8'hB0 + 8'(v), 8'h02, 8'hC0 + 8'(v), 8'h03};
    smp_point = 13'h0123; smp_stage = 3'd5;
    smp_ref = smp_val;
    @(negedge clk); smp_valid = 1'b1;
    @(negedge clk); smp_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 irq on sample", 32'(irq), 1);
    stat_rd(16'h0004, "R9 status shows sample");
    stat_rd(16'h0004, "R9 status read keeps flag");

    // R4/R5/R8 sample read with inputs changing mid-frame
    cs_lo();
    xfer(16'hC000, 16'h0004, "R4 status word");
    smp_val = '1; smp_point = 13'h1FFF; smp_stage = 3'd0;
    for (int v = 0; v < 6; v++)
      for (int p = 0; p < 3; p++)
        xfer(16'h0000, smp_ref[v][p*16 +: 16], "R5 sample value word (R8 shadow)");
    xfer(16'h0000, {3'd5, 13'h0123}, "R4 stage/point word");
    cs_hi();
    chk("R9 irq after clear", 32'(irq), 0);
    stat_rd(16'h0000, "R9 flag cleared by sample read");

    // halt status and R12
    halted = 1'b1;
    repeat (3) @(negedge clk);
    stat_rd(16'h0010, "R3 halted bit");
    chk("R12 halt not in mask", 32'(irq), 0);
    wr_reg(8'd3, 16'h0010, 16'h0010);
    chk("R12 irq on halt", 32'(irq), 1);
    halted = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 irq drops", 32'(irq), 0);

    // R6 DFT read with mid-frame change
    for (int v = 0; v < 4; v++)
      dft_val[v] = {16'h7000 + 16'(v), 16'h6100 + 16'(v), 16'h5200 + 16'(v)};
    dft_ref = dft_val;
    cs_lo();
    xfer(16'hA000, 16'h0000, "R6 status word");
    dft_val = '0;
    for (int v = 0; v < 4; v++)
      for (int p = 0; p < 3; p++)
        xfer(16'h0000, dft_ref[v][p*16 +: 16], "R6 dft word (R8 shadow)");
    xfer(16'h0000, 16'h0000, "R6 past end");
    cs_hi();

    // R7 limits
    for (int k = 0; k < 6; k++) lim_val[k] = 16'h3C00 + 16'(k * 17);
    cs_lo();
    xfer(16'hE000, 16'h0000, "R7 status word");
    for (int k = 0; k < 6; k++) xfer(16'h0000, 16'h3C00 + 16'(k * 17), "R7 limit word");
    cs_hi();

    // R11 strobes
    r0 = res_cnt; l0 = lrs_cnt;
    cs_lo(); xfer(16'h2000, 16'h0000, "R11 resume status"); cs_hi();
    chk("R11 resume once", 32'(res_cnt - r0), 1);
    chk("R11 no limit reset on resume", 32'(lrs_cnt - l0), 0);
    r0 = res_cnt; l0 = lrs_cnt;
    cs_lo(); xfer(16'h6000, 16'h0000, "R11 limrst status"); cs_hi();
    chk("R11 limit reset once", 32'(lrs_cnt - l0), 1);
    chk("R11 no resume on limit reset", 32'(res_cnt - r0), 0);
    r0 = res_cnt; l0 = lrs_cnt;
    stat_rd(16'h0000, "R11 status frame");
    chk("R11 no strobes on status", 32'((res_cnt - r0) + (lrs_cnt - l0)), 0);

    // R10 point config with a surplus seventh word
    p0 = pc_n;
    cs_lo();
    xfer(16'h1ABC, 16'h0000, "R10 status word");
    for (int k = 0; k < 7; k++) xfer(16'h5000 + 16'(k), 16'h0000, "R10 data miso");
    cs_hi();
    chk("R10 six writes", 32'(pc_n - p0), 6);
    for (int k = 0; k < 6; k++) begin
      chk("R10 sel", 32'(pc_sel[p0+k]), 32'(k));
      chk("R10 point", 32'(pc_pt[p0+k]), 32'h1ABC);
      chk("R10 data", 32'(pc_data[p0+k]), 32'h5000 + 32'(k));
    end
    chk_regs("R2 regs untouched by other frames");

    repeat (5) @(negedge clk);
    chk("R3 scoreboard drained", 32'(exp_v.size()), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R4 watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule